// File: doc/BRIEF.md
# I2C Register-Write Slave with Speed-Mode Tracking

This block is the write-side front end of an I2C slave. A fast system clock samples the two bus wires, and the block decodes START, repeated START and STOP conditions from them. It checks a fixed 7-bit device address. It acknowledges by asserting an open-drain pull-down enable on SDA. A write transaction carries four bytes: the device address with a write bit, a command byte, and then two data bytes. Once all four bytes have been acknowledged, the block presents a 7-bit register address and a 16-bit word to the register file next to it, along with a write pulse one system clock wide.

The block also tracks the bus speed mode. A master code byte, which is never acknowledged, followed by a repeated START moves the bus into high-speed mode. Further repeated STARTs leave that mode unchanged. A STOP returns the bus to fast/standard mode. A transaction that stops early, or that the block refuses, leaves the register outputs untouched.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset, sdaOe, wrStrobe and hsMode are 0, and regAddr and regData are all zeros.
- R2: When a START is followed by a first byte whose bits 7:1 equal SLAVE_ADDR and whose bit 0 is 0, the block asserts sdaOe for the whole of the ninth SCL high phase. The first byte is sent MSB first. A START or repeated START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high.
- R3: A command byte with bit 7 equal to 0 is acknowledged. Its bits 6:0 become regAddr when the write completes.
- R4: Both data bytes are acknowledged. The first data byte becomes regData[15:8] and the second becomes regData[7:0].
- R5: wrStrobe is high for exactly one system clock, after the SCL fall that ends the acknowledge of the second data byte. regAddr and regData change only in the cycle in which wrStrobe is high.
- R6: A STOP or repeated START that arrives before the second data byte's acknowledge has ended produces no wrStrobe and leaves regAddr and regData unchanged.
- R7: The block does not acknowledge, and then ignores every byte until the next START, in three cases: an address mismatch, a first byte with bit 0 equal to 1, or a command byte with bit 7 equal to 1.
- R8: A first byte matching 8'b00001xxx (the master code) is not acknowledged. A repeated START that directly follows it sets hsMode to 1.
- R9: A repeated START leaves hsMode unchanged, and a STOP clears hsMode to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock wire as seen at the pad |
| sdaIn | input | 1 | Serial data wire as seen at the pad |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regAddr | output | 7 | Target register address of the last completed write |
| regData | output | 16 | Data word of the last completed write |
| wrStrobe | output | 1 | One-cycle pulse when a write completes |
| hsMode | output | 1 | 1 while the bus is in high-speed mode |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except when it deliberately marks a START or STOP, and SCL stays at each level for several system clocks, so the two-stage synchronizer never sees both wires move in the same sample. The bench drives the wires in quarter-bit steps of ten system clocks. It moves SDA only in the middle of an SCL low phase, or while SCL is high to form a START or STOP. This keeps every edge the decoder sees unambiguous. The reference model is allowed a settling window after each wire change to absorb the synchronizer and register latency.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

  localparam int BYTE_W     = 8;
  localparam int REG_ADDR_W = 7;
  localparam int DATA_W     = 2 * BYTE_W;
  localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);

  // Events decoded from the synchronized wires
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
    logic byteDone;
  } busEv_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrBits;
    logic latchCmd;
    logic latchHi;
    logic pulseWr;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_ACK_SETUP,
    S_ACK_HIGH,
    S_ACK_HOLD,
    S_MC_WAIT,
    S_IGNORE
  } ctlState_t;

endpackage

// File: rtl/i2c_regwr_datapath.sv
module i2c_regwr_datapath
  import i2c_regwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  dpCtl_t                ctl,
  output busEv_t                ev,
  output logic [BYTE_W-1:0]     rxByte,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     regData,
  output logic                  wrStrobe
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [REG_ADDR_W-1:0] cmdStage;
  logic [BYTE_W-1:0] hiStage;

  // Input synchronizers; the idle bus level is high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    ev.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.sclRise  = sclS & ~sclPrev;
    ev.sclFall  = ~sclS & sclPrev;
    ev.byteDone = (bitCnt == BIT_CNT_W'(BYTE_W));
  end

  // Bit capture: shift on SCL rise until a full byte is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (ctl.clrBits) begin
      bitCnt <= '0;
    end else if (ev.sclRise && (bitCnt < BIT_CNT_W'(BYTE_W))) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
    end
  end

  assign rxByte = shiftReg;

  // Staging keeps outputs quiet until the write is complete
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdStage <= '0;
      hiStage  <= '0;
      regAddr  <= '0;
      regData  <= '0;
      wrStrobe <= 1'b0;
    end else begin
      if (ctl.latchCmd) cmdStage <= shiftReg[REG_ADDR_W-1:0];
      if (ctl.latchHi)  hiStage  <= shiftReg;
      if (ctl.pulseWr) begin
        regAddr <= cmdStage;
        regData <= {hiStage, shiftReg};
      end
      wrStrobe <= ctl.pulseWr;
    end
  end

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(regData) || !$stable(regAddr)) |-> wrStrobe);

endmodule

// File: rtl/i2c_regwr_control.sv
module i2c_regwr_control
  import i2c_regwr_pkg::*;
#(
  parameter logic [REG_ADDR_W-1:0] SLAVE_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t            ctl,
  output logic              sdaOe,
  output logic              hsMode
);

  localparam logic [4:0] MC_PREFIX = 5'b00001;

  ctlState_t state, nextState;
  logic [1:0] byteIdx, nextIdx;
  logic nextOe, nextHs;

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextIdx   = byteIdx;
    nextOe    = sdaOe;
    nextHs    = hsMode;
    if (ev.stopDet) begin
      nextState = S_IDLE;
      nextOe    = 1'b0;
      nextHs    = 1'b0;
    end else if (ev.startDet) begin
      if (state == S_MC_WAIT) nextHs = 1'b1;
      nextState   = S_RECV;
      nextIdx     = 2'd0;
      nextOe      = 1'b0;
      ctl.clrBits = 1'b1;
    end else begin
      unique case (state)
        S_RECV: begin
          if (ev.byteDone) begin
            unique case (byteIdx)
              2'd0: begin
                if (rxByte[7:3] == MC_PREFIX)
                  nextState = S_MC_WAIT;
                else if (rxByte[7:1] == SLAVE_ADDR && !rxByte[0])
                  nextState = S_ACK_SETUP;
                else
                  nextState = S_IGNORE;
              end
              2'd1: begin
                if (!rxByte[7]) begin
                  ctl.latchCmd = 1'b1;
                  nextState    = S_ACK_SETUP;
                end else begin
                  nextState = S_IGNORE;
                end
              end
              2'd2: begin
                ctl.latchHi = 1'b1;
                nextState   = S_ACK_SETUP;
              end
              default: nextState = S_ACK_SETUP;
            endcase
          end
        end
        S_ACK_SETUP: begin
          if (ev.sclFall) begin
            nextOe    = 1'b1;
            nextState = S_ACK_HIGH;
          end
        end
        S_ACK_HIGH: begin
          if (ev.sclRise) nextState = S_ACK_HOLD;
        end
        S_ACK_HOLD: begin
          if (ev.sclFall) begin
            nextOe = 1'b0;
            if (byteIdx == 2'd3) begin
              ctl.pulseWr = 1'b1;
              nextState   = S_IGNORE;
            end else begin
              ctl.clrBits = 1'b1;
              nextIdx     = 2'(byteIdx + 1'b1);
              nextState   = S_RECV;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteIdx <= 2'd0;
      sdaOe   <= 1'b0;
      hsMode  <= 1'b0;
    end else begin
      state   <= nextState;
      byteIdx <= nextIdx;
      sdaOe   <= nextOe;
      hsMode  <= nextHs;
    end
  end

  p_ignore_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |-> !sdaOe);

  p_mc_nack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MC_WAIT) |-> !sdaOe);

  p_stop_clears_hs_r9: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !hsMode);

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  output logic [6:0]  regAddr,
  output logic [15:0] regData,
  output logic        wrStrobe,
  output logic        hsMode
);

  busEv_t            ev;
  dpCtl_t            ctl;
  logic [BYTE_W-1:0] rxByte;

  i2c_regwr_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ctl     (ctl),
    .ev      (ev),
    .rxByte  (rxByte),
    .regAddr (regAddr),
    .regData (regData),
    .wrStrobe(wrStrobe)
  );

  i2c_regwr_control #(
    .SLAVE_ADDR(SLAVE_ADDR)
  ) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .ev    (ev),
    .rxByte(rxByte),
    .ctl   (ctl),
    .sdaOe (sdaOe),
    .hsMode(hsMode)
  );

endmodule

// File: tb/i2c_regwr_slave_tb.sv
module i2c_regwr_slave_tb;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic masterSda = 1'b1;
  logic sdaOe, wrStrobe, hsMode;
  logic [6:0] regAddr;
  logic [15:0] regData;
  logic sdaLine;

  int total = 0;
  int bad = 0;
  int settle = 0;
  int strobeSeen = 0;
  int expStrobes = 0;
  bit expHs = 1'b0;
  bit mcPendingTb = 1'b0;
  bit prevStrobe = 1'b0;
  bit done = 1'b0;
  logic [6:0] expAddr = '0;
  logic [15:0] expData = '0;

  always #5 clk = ~clk;

  assign sdaLine = masterSda & ~sdaOe;

  i2c_regwr_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regAddr(regAddr), .regData(regData),
    .wrStrobe(wrStrobe), .hsMode(hsMode)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Reference model comparison on every clock once the wires have settled
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (wrStrobe) strobeSeen++;
      check(!(wrStrobe && prevStrobe), "R5 strobe wider than one clock", 1, 0);
      prevStrobe = wrStrobe;
      if (settle > 0) settle--;
      else begin
        check(hsMode == expHs, "R9 hsMode", hsMode, expHs);
        check(regAddr == expAddr, "R3 regAddr", regAddr, expAddr);
        check(regData == expData, "R4 regData", regData, expData);
      end
    end
  end

  task automatic qwait;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic setScl(input logic v);
    sclDrv = v;
    settle = 8;
  endtask

  task automatic setSda(input logic v);
    masterSda = v;
    settle = 8;
  endtask

  task automatic startCond;
    if (mcPendingTb) expHs = 1'b1;
    mcPendingTb = 1'b0;
    setSda(1'b0);
    qwait;
    setScl(1'b0);
  endtask

  task automatic repStart;
    qwait; setSda(1'b1);
    qwait; setScl(1'b1);
    qwait; startCond;
  endtask

  task automatic stopCond;
    qwait; setSda(1'b0);
    qwait; setScl(1'b1);
    qwait;
    expHs = 1'b0;
    mcPendingTb = 1'b0;
    setSda(1'b1);
    qwait; qwait;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    for (int i = 7; i >= 0; i--) begin
      qwait; setSda(b[i]);
      qwait; setScl(1'b1);
      qwait; qwait; setScl(1'b0);
    end
    qwait; setSda(1'b1);
    qwait; setScl(1'b1);
    qwait;
    check(sdaOe == expAck, {tag, " acknowledge"}, sdaOe, expAck);
    qwait; setScl(1'b0);
  endtask

  task automatic doWrite(input logic [6:0] cmd, input logic [15:0] data);
    sendByte(8'h54, 1'b1, "R2");
    sendByte({1'b0, cmd}, 1'b1, "R3");
    sendByte(data[15:8], 1'b1, "R4");
    sendByte(data[7:0], 1'b1, "R4");
    expAddr = cmd;
    expData = data;
    expStrobes++;
  endtask

  task automatic checkStrobes(input string tag);
    qwait; qwait;
    check(strobeSeen == expStrobes, tag, strobeSeen, expStrobes);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(sdaOe == 1'b0 && wrStrobe == 1'b0 && hsMode == 1'b0, "R1 reset controls", {sdaOe, wrStrobe, hsMode}, 0);
    check(regAddr == 7'd0 && regData == 16'd0, "R1 reset data", regData, 0);
    rstN = 1'b1;
    qwait;

    // Basic write
    startCond;
    doWrite(7'h05, 16'h1234);
    stopCond;
    checkStrobes("R5 strobe count after full write");

    // Wrong address; a later matching byte is ignored
    qwait; startCond;
    sendByte(8'h56, 1'b0, "R7 mismatch");
    sendByte(8'h54, 1'b0, "R7 ignored address");
    sendByte(8'h05, 1'b0, "R7 ignored byte");
    stopCond;
    checkStrobes("R7 strobe count after mismatch");

    // Read bit set
    qwait; startCond;
    sendByte(8'h55, 1'b0, "R7 read bit");
    stopCond;

    // Command MSB set
    qwait; startCond;
    sendByte(8'h54, 1'b1, "R2");
    sendByte(8'h85, 1'b0, "R7 command msb");
    sendByte(8'h12, 1'b0, "R7 ignored data");
    stopCond;
    checkStrobes("R7 strobe count after command refusal");

    // Truncated by STOP
    qwait; startCond;
    sendByte(8'h54, 1'b1, "R2");
    sendByte(8'h10, 1'b1, "R3");
    sendByte(8'hAB, 1'b1, "R4");
    stopCond;
    checkStrobes("R6 no strobe after early stop");

    // Truncated by repeated START, then a full write
    qwait; startCond;
    sendByte(8'h54, 1'b1, "R2");
    sendByte(8'h11, 1'b1, "R3");
    sendByte(8'hCD, 1'b1, "R4");
    repStart;
    check(strobeSeen == expStrobes, "R6 no strobe after early restart", strobeSeen, expStrobes);
    doWrite(7'h7F, 16'hFFFF);
    sendByte(8'h54, 1'b0, "R5 byte after complete write");
    stopCond;
    checkStrobes("R5 strobe count after restart write");

    // High-speed entry, repeated START keeps it, STOP clears it
    qwait; startCond;
    sendByte(8'h09, 1'b0, "R8 master code");
    mcPendingTb = 1'b1;
    repStart;
    qwait;
    check(hsMode == 1'b1, "R8 hsMode after master code restart", hsMode, 1);
    doWrite(7'h00, 16'h0000);
    repStart;
    qwait;
    check(hsMode == 1'b1, "R9 hsMode kept over restart", hsMode, 1);
    doWrite(7'h33, 16'hA55A);
    stopCond;
    check(hsMode == 1'b0, "R9 hsMode cleared by stop", hsMode, 0);
    checkStrobes("R5 strobe count in high-speed writes");

    // Master code then STOP: no high-speed entry
    qwait; startCond;
    sendByte(8'h0F, 1'b0, "R8 master code variant");
    mcPendingTb = 1'b1;
    stopCond;
    qwait;
    check(hsMode == 1'b0, "R8 hsMode without restart", hsMode, 0);
    checkStrobes("R6 strobe count after master code");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R5 sequence actual=timeout expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule